// File: doc/BRIEF.md
# PCIe Link Control Register Slice

This block holds the writable Link Control fields of one switch port and decides when a retrain request written by software actually reaches the physical layer. Software writes a 16-bit word through a plain configuration write strobe and reads the current value back combinationally. The block forwards a one-cycle retrain request to the LTSSM and keeps a link-training flag. It also drives the latched common-clock, extended-sync and two bandwidth-interrupt-enable fields to the rest of the port.

On a downstream port a retrain write takes effect in the next cycle. On an upstream port it is honoured only while the register-unlock input is high. It is then held back by a counter worth about one millisecond, so that the completion for the configuration write can leave the port first. The link-training flag rises together with the retrain pulse in both cases. Common clock and extended sync influence link training. When a retrain is accepted while the LTSSM is already in Configuration or Recovery, those two fields are parked and applied when the LTSSM next enters Recovery. All other field changes apply at once.

Top module: `lnkctl_reg`

## Requirements
- R1: After reset all outputs are zero and the read word is 0x0000.
- R2: Write data bit 6 (common clock), bit 7 (extended sync), bit 10 (bandwidth interrupt enable) and bit 11 (autonomous bandwidth interrupt enable) are stored and read back at the same positions. Bits 8 and 9, and every bit outside 5..11, always read zero.
- R3: Bit 5 is the retrain request. It is write-one and always reads zero.
- R4: On a downstream port, a write with bit 5 set produces `retrain_pulse` high for exactly the cycle after the write, and `link_training` rises in that same cycle.
- R5: `link_training` clears one cycle after `ltssm_state` equals L0 (code 3). If a retrain pulse is issued in that cycle, the set wins. The LTSSM codes are Detect=0, Polling=1, Configuration=2, L0=3 and Recovery=4.
- R6: When a retrain is accepted while `ltssm_state` is Configuration (2) or Recovery (4), the common clock and extended sync values of that write are held and leave the outputs unchanged. They are applied in the cycle after the LTSSM next enters Recovery. The interrupt enables of the same write apply at once.
- R7: A write with bit 5 clear applies common clock and extended sync in the next cycle and discards any held values.
- R8: On an upstream port with `reg_unlock` low, bit 5 has no effect: no pulse and no flag change.
- R9: On an upstream port with `reg_unlock` high, the retrain pulse and the flag rise exactly CYC_PER_MS cycles after the cycle following the write, and not earlier.
- R10: On an upstream port, a retrain write while the delay is running is ignored. Lowering `reg_unlock` or the upstream role cancels a running delay.
- R11: Both interrupt enables read and drive zero on an upstream port or when `bw_notify_cap` is low. A value written under those conditions is stored as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wr_data | input | 16 | Write data |
| cfg_rd_data | output | 16 | Current register value |
| is_upstream | input | 1 | Port role: 1 for upstream, 0 for downstream |
| reg_unlock | input | 1 | Allows retraining from the upstream port |
| bw_notify_cap | input | 1 | Link bandwidth notification is supported |
| ltssm_state | input | 4 | Current LTSSM state code |
| retrain_pulse | output | 1 | One-cycle retrain request to the LTSSM |
| link_training | output | 1 | Link training in progress flag |
| ctl_common_clk | output | 1 | Applied common clock setting |
| ctl_ext_sync | output | 1 | Applied extended sync setting |
| ctl_bw_int_en | output | 1 | Bandwidth interrupt enable |
| ctl_abw_int_en | output | 1 | Autonomous bandwidth interrupt enable |

## Verification
Two functions can meet in one cycle. The retrain path sets the training flag while an LTSSM at L0 clears it. The bench writes a retrain with the state already at L0, expects the flag high in the following cycle, and expects it low one cycle later. A second collision is between the apply of parked settings on Recovery entry and a later plain write. A scoreboard queue matches every retrain pulse against the exact cycle predicted for it, so a pulse that is missing, extra or late (as a reloaded upstream delay would produce) is reported.

// File: rtl/lnkctl_pkg.sv
package lnkctl_pkg;
  typedef enum logic [3:0] {
    LT_DETECT   = 4'd0,
    LT_POLLING  = 4'd1,
    LT_CONFIG   = 4'd2,
    LT_L0       = 4'd3,
    LT_RECOVERY = 4'd4,
    LT_L0S      = 4'd5,
    LT_L1       = 4'd6,
    LT_L2       = 4'd7,
    LT_DISABLED = 4'd8,
    LT_LOOPBACK = 4'd9,
    LT_HOTRST   = 4'd10
  } ltssm_e;

  localparam int unsigned REG_W     = 16;
  localparam int unsigned BIT_RETRN = 5;
  localparam int unsigned BIT_CCLK  = 6;
  localparam int unsigned BIT_XSYNC = 7;
  localparam int unsigned BIT_BWIE  = 10;
  localparam int unsigned BIT_ABWIE = 11;

  typedef struct packed {
    logic cclk;
    logic xsync;
  } trn_fields_t;
endpackage

// File: rtl/lnkctl_retrain.sv
module lnkctl_retrain #(
  parameter int unsigned CYC_PER_MS = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic is_upstream,
  input  logic reg_unlock,
  input  logic l0_reached,
  output logic accepted,
  output logic retrain_pulse,
  output logic link_training
);
  localparam int unsigned CW = $clog2(CYC_PER_MS + 1);

  logic [CW-1:0] cnt;
  logic          idle;
  logic          up_armed;
  logic          fire_now;
  logic          expire;

  assign idle     = (cnt == '0);
  assign up_armed = is_upstream && reg_unlock;
  assign accepted = req && (!is_upstream || (reg_unlock && idle));
  assign fire_now = accepted && !is_upstream;
  assign expire   = up_armed && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt           <= '0;
      retrain_pulse <= 1'b0;
      link_training <= 1'b0;
    end else begin
      if (!up_armed)
        cnt <= '0;
      else if (accepted)
        cnt <= CW'(CYC_PER_MS);
      else if (!idle)
        cnt <= cnt - CW'(1);

      retrain_pulse <= fire_now || expire;

      if (fire_now || expire)
        link_training <= 1'b1;
      else if (l0_reached)
        link_training <= 1'b0;
    end
  end
endmodule

// File: rtl/lnkctl_fields.sv
module lnkctl_fields
  import lnkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             defer,
  input  ltssm_e           ltssm,
  input  logic             bw_allowed,
  output trn_fields_t      live,
  output logic             bwie,
  output logic             abwie
);
  trn_fields_t pend;
  logic        pend_vld;
  ltssm_e      prev;
  logic        rec_entry;
  trn_fields_t wr_trn;

  assign rec_entry   = (ltssm == LT_RECOVERY) && (prev != LT_RECOVERY);
  assign wr_trn.cclk  = wr_data[BIT_CCLK];
  assign wr_trn.xsync = wr_data[BIT_XSYNC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev     <= LT_DETECT;
      live     <= '0;
      pend     <= '0;
      pend_vld <= 1'b0;
      bwie     <= 1'b0;
      abwie    <= 1'b0;
    end else begin
      prev <= ltssm;
      if (rec_entry && pend_vld) begin
        live     <= pend;
        pend_vld <= 1'b0;
      end
      if (wr_en) begin
        bwie  <= wr_data[BIT_BWIE] && bw_allowed;
        abwie <= wr_data[BIT_ABWIE] && bw_allowed;
        if (defer) begin
          pend     <= wr_trn;
          pend_vld <= 1'b1;
        end else begin
          live     <= wr_trn;
          pend_vld <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lnkctl_reg.sv
module lnkctl_reg
  import lnkctl_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 200000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [15:0] cfg_wr_data,
  output logic [15:0] cfg_rd_data,
  input  logic        is_upstream,
  input  logic        reg_unlock,
  input  logic        bw_notify_cap,
  input  logic [3:0]  ltssm_state,
  output logic        retrain_pulse,
  output logic        link_training,
  output logic        ctl_common_clk,
  output logic        ctl_ext_sync,
  output logic        ctl_bw_int_en,
  output logic        ctl_abw_int_en
);
  ltssm_e      ltssm;
  logic        accepted;
  logic        in_trn;
  logic        bw_allowed;
  trn_fields_t live;
  logic        bwie;
  logic        abwie;

  assign ltssm      = ltssm_e'(ltssm_state);
  assign in_trn     = (ltssm == LT_CONFIG) || (ltssm == LT_RECOVERY);
  assign bw_allowed = !is_upstream && bw_notify_cap;

  lnkctl_retrain #(.CYC_PER_MS(CYC_PER_MS)) u_rt (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (cfg_wr_en && cfg_wr_data[BIT_RETRN]),
    .is_upstream   (is_upstream),
    .reg_unlock    (reg_unlock),
    .l0_reached    (ltssm == LT_L0),
    .accepted      (accepted),
    .retrain_pulse (retrain_pulse),
    .link_training (link_training)
  );

  lnkctl_fields u_fld (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .defer      (accepted && in_trn),
    .ltssm      (ltssm),
    .bw_allowed (bw_allowed),
    .live       (live),
    .bwie       (bwie),
    .abwie      (abwie)
  );

  assign ctl_common_clk = live.cclk;
  assign ctl_ext_sync   = live.xsync;
  assign ctl_bw_int_en  = bwie && bw_allowed;
  assign ctl_abw_int_en = abwie && bw_allowed;

  always_comb begin
    cfg_rd_data            = '0;
    cfg_rd_data[BIT_CCLK]  = ctl_common_clk;
    cfg_rd_data[BIT_XSYNC] = ctl_ext_sync;
    cfg_rd_data[BIT_BWIE]  = ctl_bw_int_en;
    cfg_rd_data[BIT_ABWIE] = ctl_abw_int_en;
  end
endmodule

// File: rtl/lnkctl_reg_chk.sv
module lnkctl_reg_chk #(
  parameter int unsigned CYC_PER_MS = 200000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [15:0] cfg_wr_data,
  input logic [15:0] cfg_rd_data,
  input logic        is_upstream,
  input logic        reg_unlock,
  input logic        bw_notify_cap,
  input logic [3:0]  ltssm_state,
  input logic        retrain_pulse,
  input logic        link_training,
  input logic        ctl_common_clk,
  input logic        ctl_ext_sync,
  input logic        ctl_bw_int_en,
  input logic        ctl_abw_int_en
);
  logic [3:0] prev_st;
  logic       entry;
  logic       in_trn;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_st <= 4'd0;
    else        prev_st <= ltssm_state;
  end

  assign entry  = (ltssm_state == 4'd4) && (prev_st != 4'd4);
  assign in_trn = (ltssm_state == 4'd2) || (ltssm_state == 4'd4);

  AST_DOWN_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_upstream && cfg_wr_en && cfg_wr_data[5]) |=> (retrain_pulse && link_training)); // R4

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_pulse |-> link_training); // R9

  AST_L0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_training && ltssm_state == 4'd3) |=> (!link_training || retrain_pulse)); // R5

  AST_LOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_upstream && !reg_unlock) |=> !retrain_pulse); // R8

  AST_BW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_upstream || !bw_notify_cap) |-> (!ctl_bw_int_en && !ctl_abw_int_en)); // R11

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_upstream && cfg_wr_en && cfg_wr_data[5] && in_trn && !entry)
      |=> ($stable(ctl_common_clk) && $stable(ctl_ext_sync))); // R6

  AST_PLAIN_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_wr_data[5])
      |=> (ctl_common_clk == $past(cfg_wr_data[6]) && ctl_ext_sync == $past(cfg_wr_data[7]))); // R7
endmodule

bind lnkctl_reg lnkctl_reg_chk #(.CYC_PER_MS(CYC_PER_MS)) u_chk (.*);

// File: tb/sim_lnkctl_reg.sv
`timescale 1ns/1ps
module sim_lnkctl_reg;
  import lnkctl_pkg::*;

  localparam int unsigned D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        is_upstream = 1'b0;
  logic        reg_unlock = 1'b0;
  logic        bw_notify_cap = 1'b1;
  logic [3:0]  ltssm_state = 4'd0;
  logic        retrain_pulse, link_training;
  logic        ctl_common_clk, ctl_ext_sync, ctl_bw_int_en, ctl_abw_int_en;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  int    exp_cyc[$];
  string exp_req[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lnkctl_reg #(.CYC_PER_MS(D)) u0 (.*);

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", r, act, exp);
    end
  endtask

  // drive one write; dly>0 pushes the cycle in which a pulse must appear
  task automatic wr(input logic [15:0] d, input int dly, input string r);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    if (dly > 0) begin
      exp_cyc.push_back(cyc + dly);
      exp_req.push_back(r);
    end
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && retrain_pulse) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        failures++;
        $display("FAIL R8/R10 unexpected retrain pulse actual_cycle=%0d expected=none", cyc);
      end else begin
        automatic int    e = exp_cyc.pop_front();
        automatic string r = exp_req.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL %s pulse cycle actual=%0d expected=%0d", r, cyc, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 read", cfg_rd_data, 16'h0000);
    chk("R1 outs", {10'd0, retrain_pulse, link_training, ctl_common_clk, ctl_ext_sync,
                    ctl_bw_int_en, ctl_abw_int_en}, 16'h0000);

    // R2: field positions, read-only bits 8/9 and others zero
    wr(16'hFFDF, 0, "R2");
    chk("R2 readback", cfg_rd_data, 16'h0CC0);
    chk("R2 outs", {12'd0, ctl_common_clk, ctl_ext_sync, ctl_bw_int_en, ctl_abw_int_en}, 16'h000F);

    // R4/R3: downstream retrain, Detect state
    wr(16'h0CE0, 1, "R4");
    chk("R4 flag", {15'd0, link_training}, 16'd1);
    chk("R3 reads zero", cfg_rd_data, 16'h0CC0);
    idle(2);
    chk("R5 flag held off L0", {15'd0, link_training}, 16'd1);
    ltssm_state = LT_L0;
    idle(1);
    chk("R5 cleared at L0", {15'd0, link_training}, 16'd0);

    // R5: set and clear in the same cycle
    wr(16'h0CE0, 1, "R5");
    chk("R5 set wins", {15'd0, link_training}, 16'd1);
    idle(1);
    chk("R5 clear after", {15'd0, link_training}, 16'd0);

    // R6: deferral from Configuration
    ltssm_state = LT_CONFIG;
    wr(16'h0820, 1, "R6");
    chk("R6 held, bw immediate", cfg_rd_data, 16'h08C0);
    ltssm_state = LT_RECOVERY;
    idle(1);
    chk("R6 applied on entry", cfg_rd_data, 16'h0800);

    // R7: plain write discards held values
    wr(16'h0860, 1, "R6");
    chk("R6 held in Recovery", cfg_rd_data, 16'h0800);
    wr(16'h0880, 0, "R7");
    chk("R7 immediate", cfg_rd_data, 16'h0880);
    ltssm_state = LT_L0;
    idle(1);
    ltssm_state = LT_RECOVERY;
    idle(2);
    chk("R7 pending discarded", cfg_rd_data, 16'h0880);

    // R11: capability absent
    ltssm_state = LT_DETECT;
    bw_notify_cap = 1'b0;
    idle(1);
    chk("R11 masked no cap", cfg_rd_data, 16'h0080);
    wr(16'h0C80, 0, "R11");
    bw_notify_cap = 1'b1;
    idle(1);
    chk("R11 stored as zero", cfg_rd_data, 16'h0080);

    // R8: upstream locked
    is_upstream = 1'b1;
    wr(16'h0CA0, 0, "R8");
    idle(D + 4);
    chk("R8 no flag", {15'd0, link_training}, 16'd0);
    chk("R11 masked upstream", cfg_rd_data, 16'h0080);

    // R9/R10: upstream unlocked, delayed request, second write ignored
    reg_unlock = 1'b1;
    wr(16'h00A0, 1 + D, "R9");
    idle(5);
    chk("R9 no early flag", {15'd0, link_training}, 16'd0);
    wr(16'h00A0, 0, "R10");
    idle(D);
    chk("R9 flag after delay", {15'd0, link_training}, 16'd1);
    idle(D + 4);

    // R10: dropping unlock cancels
    ltssm_state = LT_L0;
    idle(1);
    ltssm_state = LT_DETECT;
    wr(16'h00A0, 0, "R10");
    idle(3);
    reg_unlock = 1'b0;
    idle(D + 4);
    chk("R10 cancelled", {15'd0, link_training}, 16'd0);

    chk("R4/R9 all pulses seen", 16'(exp_cyc.size()), 16'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule